// File: doc/BRIEF.md
# Timing Generator Startup Delay

This block decides the clock cycle in which a display timing generator begins its sequence, measured from the incoming sync. It first waits for a vertical reference. It then counts horizontal references to pass a programmed number of lines. The horizontal reference that completes that line count becomes the anchor. From the anchor it counts a programmed number of pixel clocks and then emits a one-cycle start strobe.

A mode input chooses where the references come from. In dedicated-sync mode they are the rising edges of the HS and VS inputs. In embedded mode they are single-cycle strobes from an upstream end-of-active-video decoder and from a line-counter comparator.

Both delays may be larger than a line or a frame. The counts then continue across later lines and frames without clipping. Sync arriving while a start is pending does not disturb the count. Registers outside the block usually reset the horizontal delay to 61 pixels and the vertical delay to 3 lines. The package carries these values as constants.

Top module: `tg_start_delay`

## Requirements
- R1: After reset, start_o is low and stays low until a vertical reference has been accepted and the full delay has elapsed.
- R2: With embedded_i low, a horizontal reference is a rising edge of hs_i and a vertical reference is a rising edge of vs_i. A level held high produces only one reference, and eav_stb_i and lmatch_stb_i are ignored.
- R3: With embedded_i high, each clock in which eav_stb_i is high is a horizontal reference and each clock in which lmatch_stb_i is high is a vertical reference. hs_i and vs_i are ignored.
- R4: The anchor is the (v_delay_i+1)-th horizontal reference counted from the accepted vertical reference, where a horizontal reference sampled on the same edge counts. With v_delay_i = 0, that same-edge reference is itself the anchor.
- R5: If the anchor is sampled on clock edge k, start_o is high in the cycle that follows edge k + h_delay_i + 2. This includes h_delay_i = 0.
- R6: start_o is never high for two consecutive cycles.
- R7: Horizontal references that arrive during the pixel count neither restart it nor stop it, so a delay longer than a line lands in a later line.
- R8: A vertical reference that arrives while a start is pending is ignored, and line counting continues. A vertical delay longer than a frame therefore lands in a later frame.
- R9: A vertical reference sampled on or after the edge that raises start_o arms a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| embedded_i | input | 1 | 0: references from HS/VS edges; 1: references from strobes |
| hs_i | input | 1 | Horizontal sync, active high |
| vs_i | input | 1 | Vertical sync, active high |
| eav_stb_i | input | 1 | One-cycle end-of-active-video strobe (embedded mode) |
| lmatch_stb_i | input | 1 | One-cycle line-counter match strobe (embedded mode) |
| h_delay_i | input | H_W | Pixel clocks from anchor to start |
| v_delay_i | input | V_W | Lines from vertical reference to anchor |
| start_o | output | 1 | One-cycle startup strobe |

## Verification
The bench uses the default widths, 13-bit pixel and 11-bit line delays, so the full delay registers are driven. It pairs them with short synthetic lines of 8 to 67 clocks and frames of 3 to 10 lines. Delays of up to 200 pixels and 14 lines therefore run well past a line and a frame, and the wrap-around paths of R7 and R8 are exercised many times within a short run. Garbage on the inputs of the mode that is not selected covers the ignore paths of R2 and R3.

// File: rtl/tgsd_pkg.sv
package tgsd_pkg;

  // Sequencer phase
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_LINES  = 2'd1,
    PH_PIXELS = 2'd2
  } phase_t;

  // Customary reset values of the delay registers held outside this block
  localparam int unsigned H_DLY_RESET = 61;
  localparam int unsigned V_DLY_RESET = 3;

  // Number of clock edges from the sampling edge of the anchor to the edge
  // that raises the start strobe, for a pixel delay d
  function automatic int unsigned start_latency(input int unsigned d);
    return d + 2;
  endfunction

endpackage

// File: rtl/tgsd_edge.sv
module tgsd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);

  logic samp_q;
  logic hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      samp_q <= lvl_i;
      hist_q <= samp_q;
    end
  end

  assign rise_o = samp_q & ~hist_q;

endmodule

// File: rtl/tgsd_refsel.sv
module tgsd_refsel #(
  parameter int unsigned N_REF = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             embedded_i,
  input  logic [N_REF-1:0] lvl_i,
  input  logic [N_REF-1:0] stb_i,
  output logic [N_REF-1:0] evt_o
);

  logic [N_REF-1:0] lvl_rise;
  logic [N_REF-1:0] stb_q;
  logic             mode_q;

  generate
    for (genvar g = 0; g < N_REF; g++) begin : g_ch
      tgsd_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl_i[g]),
        .rise_o (lvl_rise[g])
      );
    end
  endgenerate

  // Strobes and mode take one register so both sources share the same latency
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      stb_q  <= stb_i;
      mode_q <= embedded_i;
    end
  end

  assign evt_o = mode_q ? stb_q : lvl_rise;

endmodule

// File: rtl/tgsd_seq.sv
module tgsd_seq
  import tgsd_pkg::*;
#(
  parameter int unsigned H_W = 13,
  parameter int unsigned V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           h_evt_i,
  input  logic           v_evt_i,
  input  logic [H_W-1:0] h_dly_i,
  input  logic [V_W-1:0] v_dly_i,
  output logic           start_o,
  output phase_t         phase_o,
  output logic [V_W-1:0] lines_o,
  output logic [H_W-1:0] pix_o,
  output logic           anchor_o,
  output logic           fire_o
);

  phase_t         phase_q;
  logic [V_W-1:0] lines_q;
  logic [H_W-1:0] pix_q;
  logic           start_q;

  logic           v_accept;
  logic           armed;
  logic [V_W-1:0] lines_eff;
  logic           anchor;
  logic           fire;

  function automatic logic [V_W-1:0] lines_after(input logic [V_W-1:0] rem,
                                                 input logic          hit);
    return hit ? rem - V_W'(1) : rem;
  endfunction

  function automatic logic [H_W-1:0] pix_after(input logic [H_W-1:0] rem);
    return rem - H_W'(1);
  endfunction

  assign v_accept  = (phase_q == PH_IDLE) && v_evt_i;
  assign armed     = v_accept || (phase_q == PH_LINES);
  assign lines_eff = v_accept ? v_dly_i : lines_q;
  assign anchor    = armed && h_evt_i && (lines_eff == '0);
  assign fire      = (phase_q == PH_PIXELS) && (pix_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      lines_q <= '0;
      pix_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= fire;
      unique case (phase_q)
        PH_IDLE, PH_LINES: begin
          if (anchor) begin
            phase_q <= PH_PIXELS;
            pix_q   <= h_dly_i;
          end else if (armed) begin
            phase_q <= PH_LINES;
            lines_q <= lines_after(lines_eff, h_evt_i);
          end
        end
        PH_PIXELS: begin
          if (fire) phase_q <= PH_IDLE;
          else      pix_q   <= pix_after(pix_q);
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign start_o  = start_q;
  assign phase_o  = phase_q;
  assign lines_o  = lines_q;
  assign pix_o    = pix_q;
  assign anchor_o = anchor;
  assign fire_o   = fire;

endmodule

// File: rtl/tg_start_delay.sv
module tg_start_delay
  import tgsd_pkg::*;
#(
  parameter int unsigned H_W = 13,
  parameter int unsigned V_W = 11
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           embedded_i,
  input  logic           hs_i,
  input  logic           vs_i,
  input  logic           eav_stb_i,
  input  logic           lmatch_stb_i,
  input  logic [H_W-1:0] h_delay_i,
  input  logic [V_W-1:0] v_delay_i,
  output logic           start_o
);

  localparam int unsigned REF_H = 0;
  localparam int unsigned REF_V = 1;

  logic [1:0]     ref_evt;
  logic           h_evt_w;
  logic           v_evt_w;
  phase_t         phase_w;
  logic [V_W-1:0] lines_w;
  logic [H_W-1:0] pix_w;
  logic           anchor_w;
  logic           fire_w;

  tgsd_refsel #(.N_REF(2)) u_refsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .embedded_i (embedded_i),
    .lvl_i      ({vs_i, hs_i}),
    .stb_i      ({lmatch_stb_i, eav_stb_i}),
    .evt_o      (ref_evt)
  );

  assign h_evt_w = ref_evt[REF_H];
  assign v_evt_w = ref_evt[REF_V];

  tgsd_seq #(.H_W(H_W), .V_W(V_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .h_evt_i  (h_evt_w),
    .v_evt_i  (v_evt_w),
    .h_dly_i  (h_delay_i),
    .v_dly_i  (v_delay_i),
    .start_o  (start_o),
    .phase_o  (phase_w),
    .lines_o  (lines_w),
    .pix_o    (pix_w),
    .anchor_o (anchor_w),
    .fire_o   (fire_w)
  );

endmodule

// File: rtl/tgsd_chk.sv
module tgsd_chk
  import tgsd_pkg::*;
#(
  parameter int unsigned H_W = 13,
  parameter int unsigned V_W = 11
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start_o,
  input phase_t         phase,
  input logic [V_W-1:0] lines,
  input logic [H_W-1:0] pix,
  input logic           h_evt,
  input logic           v_evt,
  input logic           anchor,
  input logic [H_W-1:0] h_dly
);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  p_idle_at_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (phase == PH_IDLE));

  p_anchor_on_href_r4: assert property (@(posedge clk) disable iff (!rst_n)
    anchor |-> h_evt);

  p_load_pixels_r5: assert property (@(posedge clk) disable iff (!rst_n)
    anchor |=> (phase == PH_PIXELS) && (pix == $past(h_dly)));

  p_pix_carry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PIXELS) && (pix != '0) |=>
      (phase == PH_PIXELS) && (pix == H_W'($past(pix) - H_W'(1))));

  p_vref_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LINES) && v_evt && !h_evt |=> (phase == PH_LINES) && $stable(lines));

  p_no_pulse_early_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_PIXELS) |=> !start_o);

endmodule

bind tg_start_delay tgsd_chk #(.H_W(H_W), .V_W(V_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_o (start_o),
  .phase   (phase_w),
  .lines   (lines_w),
  .pix     (pix_w),
  .h_evt   (h_evt_w),
  .v_evt   (v_evt_w),
  .anchor  (anchor_w),
  .h_dly   (h_delay_i)
);

// File: tb/tg_start_delay_bench.sv
module tg_start_delay_bench;
  import tgsd_pkg::*;

  localparam int unsigned H_W = 13;
  localparam int unsigned V_W = 11;
  localparam int WATCHDOG_CYC = 190000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           embedded = 1'b0;
  logic           hs = 1'b0, vs = 1'b0, eav = 1'b0, lmatch = 1'b0;
  logic [H_W-1:0] hd = '0;
  logic [V_W-1:0] vd = '0;
  logic           start;

  always #4 clk = ~clk;  // 125 MHz

  tg_start_delay #(.H_W(H_W), .V_W(V_W)) u_tg_start_delay (
    .clk          (clk),
    .rst_n        (rst_n),
    .embedded_i   (embedded),
    .hs_i         (hs),
    .vs_i         (vs),
    .eav_stb_i    (eav),
    .lmatch_stb_i (lmatch),
    .h_delay_i    (hd),
    .v_delay_i    (vd),
    .start_o      (start)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    finished = 1'b0;

  // Reference model, expressed as edge indices
  int m_edge, m_fire, m_phase, m_lines;
  bit m_prev_hs, m_prev_vs, exp_now;
  int obs_pulses, exp_pulses;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_fire = -1; m_phase = 0; m_lines = 0;
      m_prev_hs = 0; m_prev_vs = 0; exp_now = 0;
    end else begin
      bit eh, ev;
      m_edge++;
      exp_now = (m_edge == m_fire);
      eh = embedded ? eav    : (hs && !m_prev_hs);
      ev = embedded ? lmatch : (vs && !m_prev_vs);
      m_prev_hs = hs; m_prev_vs = vs;
      if (m_phase == 2 && m_edge >= m_fire) m_phase = 0;   // R9 re-arm point
      if (m_phase == 0 && ev) begin m_phase = 1; m_lines = int'(vd); end
      if (m_phase == 1 && eh) begin
        if (m_lines == 0) begin
          m_phase = 2;
          m_fire  = m_edge + int'(start_latency(int'(hd)));
        end else m_lines--;
      end
    end
  end

  // Cycle-by-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      n_cmp++;
      if (start) obs_pulses++;
      if (exp_now) exp_pulses++;
      if (start !== exp_now) begin
        n_bad++;
        $display("FAIL %s edge %0d start_o actual=%0b expected=%0b",
                 cur_tag, m_edge, start, exp_now);
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic do_reset(input logic md, input int h, input int v);
    @(negedge clk);
    rst_n = 1'b0;
    embedded = md; hd = H_W'(h); vd = V_W'(v);
    hs = 0; vs = 0; eav = 0; lmatch = 0;
    repeat (3) @(negedge clk);
    check_val("R1 start_o in reset", int'(start), 0);
    rst_n = 1'b1;
    obs_pulses = 0; exp_pulses = 0;
  endtask

  // Synthetic raster; the unselected mode's inputs carry garbage when junk=1
  task automatic run_frames(input int ll, input int fl, input int nf, input bit junk);
    for (int f = 0; f < nf; f++)
      for (int l = 0; l < fl; l++)
        for (int p = 0; p < ll; p++) begin
          @(negedge clk);
          if (embedded) begin
            eav    = (p == 0);
            lmatch = (p == 0) && (l == 0);
            hs = junk ? 1'($urandom) : 1'b0;
            vs = junk ? 1'($urandom) : 1'b0;
          end else begin
            hs = (p < 4);
            vs = (l < 2);
            eav    = junk ? 1'($urandom) : 1'b0;
            lmatch = junk ? 1'($urandom) : 1'b0;
          end
        end
    @(negedge clk);
    hs = 0; vs = 0; eav = 0; lmatch = 0;
  endtask

  task automatic scenario(input string tag, input logic md, input int h, input int v,
                          input int ll, input int fl, input int nf, input bit junk,
                          input bit want_pulse);
    do_reset(md, h, v);
    cur_tag = tag;
    run_frames(ll, fl, nf, junk);
    repeat (h + 8) @(negedge clk);
    check_val({tag, " pulse count"}, obs_pulses, exp_pulses);
    if (want_pulse) begin
      n_cmp++;
      if (exp_pulses == 0) begin
        n_bad++;
        $display("FAIL %s actual=0 pulses expected>=1", tag);
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R1: only horizontal sync, no vertical reference -> never starts
    do_reset(1'b0, 5, 0);
    cur_tag = "R1";
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      hs = ((i % 20) < 3);
    end
    @(negedge clk); hs = 0;
    check_val("R1 no start without vertical reference", obs_pulses, 0);

    scenario("R2 dedicated edges, reset delays", 1'b0, int'(H_DLY_RESET),
             int'(V_DLY_RESET), 100, 8, 3, 1'b1, 1'b1);
    scenario("R3 embedded strobes, sync ignored", 1'b1, int'(H_DLY_RESET),
             int'(V_DLY_RESET), 100, 8, 3, 1'b1, 1'b1);
    scenario("R4 zero line delay", 1'b0, 10, 0, 30, 5, 3, 1'b0, 1'b1);
    scenario("R5 zero pixel delay", 1'b1, 0, 2, 20, 4, 3, 1'b0, 1'b1);
    scenario("R7 pixel delay past line end", 1'b0, 150, 1, 40, 6, 3, 1'b1, 1'b1);
    scenario("R8 line delay past frame end", 1'b1, 7, 20, 16, 6, 6, 1'b0, 1'b1);
    scenario("R9 repeated starts every frame", 1'b0, 3, 1, 12, 4, 6, 1'b0, 1'b1);

    for (int t = 0; t < 8; t++) begin
      int ll, fl, h, v, nf;
      logic md;
      ll = 8 + int'($urandom % 60);
      fl = 3 + int'($urandom % 8);
      h  = int'($urandom % 200);
      v  = int'($urandom % 15);
      md = 1'($urandom);
      nf = (v + h / ll) / fl + 3;
      scenario("R6 random raster", md, h, v, ll, fl, nf, 1'($urandom), 1'b1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog %s actual=running expected=done", cur_tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule